// File: doc/BRIEF.md
# Clock and Reset Control Register File

This block is the software-visible register file of a clock, reset and PLL controller. It sits on a plain 32-bit peripheral bus with a 12-bit byte address (a 4 KB window), separate read and write strobes, write data and registered read data. It holds the oscillator setup word, the settings of three PLLs (core, DDR, Ethernet), the core clock source select, the per-device reset mask and a clock-mux status word. Every stored word is also driven out on its own port so neighbouring clock and reset logic can consume it directly.

The block stands in for hardware whose oscillator and PLLs are always stable. The oscillator ready bit, and each PLL's lock bit and internal-feedback select bit, read as 1 after reset and after every write, whatever value software writes. No PLL, clock generation or reset sequencing is modelled.

Bus accesses are tracked by a small state machine with five states: ACC_IDLE (no access in the previous cycle), ACC_RDONE (mapped read in the previous cycle), ACC_WDONE (mapped write only), ACC_RFAULT (read of an unmapped or misaligned address) and ACC_WFAULT (write only, unmapped or misaligned). Each cycle the next state follows that cycle's strobes: a read strobe moves to ACC_RDONE or ACC_RFAULT, else a write strobe moves to ACC_WDONE or ACC_WFAULT, else to ACC_IDLE. Read-data-valid is high in the two read states, the error flag in the two fault states.

Top module: `clkrst_regs`

## Requirements
- R1: After synchronous active-high reset: oscillator word 0xC000_0000 (enable bit 30, ready bit 31), each PLL config0 word 0x8201_87C1 (R divider bits [5:0]=1, F divider bits [14:6]=31, Q divider bits [17:15]=3, feedback-select bit 25=1, lock bit 31=1), core clock select 0x0000_0001, the two PLL config1 words, device reset mask and clock-mux status 0.
- R2: A write to byte offset 0x00 stores the write data into the oscillator word with bit 31 forced to 1; all other bits are kept as written.
- R3: A write to a PLL config0 word (core 0x04, DDR 0x0C, Ethernet 0x1C) stores the write data with bits 25 and 31 forced to 1.
- R4: Writes to DDR config1 (0x10), Ethernet config1 (0x20; clock-enable at bit 24), core clock select (0x24), device reset mask (0x28) and clock-mux status (0x2C) store the data unchanged.
- R5: A read strobe returns the addressed word on the read data port and raises read-data-valid in the following cycle only; read data holds its value when no read is made.
- R6: A read of an offset that is not mapped, or whose low two address bits are not 00, returns 0.
- R7: A write to an unmapped or misaligned address changes no register.
- R8: The error flag is high for exactly the cycle after a strobe cycle whose address is unmapped or misaligned, and low otherwise.
- R9: When read and write strobes are both high for the same register in one cycle, the read returns the value held before that write and the write still takes effect.
- R10: A write alters only the addressed register; every other exported word keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 12 | Byte address within the window |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| bus_err | output | 1 | Unmapped or misaligned access flag |
| osc_cfg | output | 32 | Oscillator setup word |
| core_pll_cfg0 | output | 32 | Core PLL divider and status word |
| ddr_pll_cfg0 | output | 32 | DDR PLL divider and status word |
| ddr_pll_cfg1 | output | 32 | DDR PLL second word |
| eth_pll_cfg0 | output | 32 | Ethernet PLL divider and status word |
| eth_pll_cfg1 | output | 32 | Ethernet PLL second word |
| core_clk_sel | output | 32 | Core clock source select |
| dev_rst_mask | output | 32 | Device reset mask |
| clk_mux_stat | output | 32 | Clock-mux status word |

## Verification
The two functions that meet in one cycle are a register read and a register write: the bench raises both strobes on the same mapped address and expects the old contents on the read port while the exported word shows the newly written value, forced bits included. It also raises both strobes on an unmapped address, where a read result of 0, a single error cycle and unchanged exports must all be seen together. The behavioural model judges these cases by taking the read value before applying the write, and compares every output on every clock.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 12;
    localparam int unsigned WORD_W   = ADDR_W - 2;
    localparam int unsigned NUM_REGS = 9;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [WORD_W-1:0] word_t;

    // Register indices inside the file
    localparam int unsigned IX_OSC   = 0;
    localparam int unsigned IX_CPLL0 = 1;
    localparam int unsigned IX_DPLL0 = 2;
    localparam int unsigned IX_DPLL1 = 3;
    localparam int unsigned IX_EPLL0 = 4;
    localparam int unsigned IX_EPLL1 = 5;
    localparam int unsigned IX_CSEL  = 6;
    localparam int unsigned IX_DRST  = 7;
    localparam int unsigned IX_MUX   = 8;

    // Field positions
    localparam int unsigned OSC_EN_BIT   = 30;
    localparam int unsigned OSC_RDY_BIT  = 31;
    localparam int unsigned PLL_R_LSB    = 0;
    localparam int unsigned PLL_F_LSB    = 6;
    localparam int unsigned PLL_Q_LSB    = 15;
    localparam int unsigned PLL_FB_BIT   = 25;
    localparam int unsigned PLL_LOCK_BIT = 31;
    localparam int unsigned PLL_CKE_BIT  = 24;

    localparam data_t OSC_FORCE  = data_t'(1) << OSC_RDY_BIT;
    localparam data_t OSC_RESET  = OSC_FORCE | (data_t'(1) << OSC_EN_BIT);
    localparam data_t PLL0_FORCE = (data_t'(1) << PLL_LOCK_BIT) | (data_t'(1) << PLL_FB_BIT);
    localparam data_t PLL0_RESET = PLL0_FORCE | (data_t'(3) << PLL_Q_LSB)
                                 | (data_t'(31) << PLL_F_LSB) | (data_t'(1) << PLL_R_LSB);
    localparam data_t CSEL_RESET = data_t'(1);

    typedef enum logic [2:0] {
        ACC_IDLE   = 3'd0,
        ACC_RDONE  = 3'd1,
        ACC_WDONE  = 3'd2,
        ACC_RFAULT = 3'd3,
        ACC_WFAULT = 3'd4
    } acc_state_e;

    // Word offset (byte offset / 4) of each register
    function automatic word_t reg_word(input int unsigned ix);
        case (ix)
            IX_OSC:   return word_t'(0);
            IX_CPLL0: return word_t'(1);
            IX_DPLL0: return word_t'(3);
            IX_DPLL1: return word_t'(4);
            IX_EPLL0: return word_t'(7);
            IX_EPLL1: return word_t'(8);
            IX_CSEL:  return word_t'(9);
            IX_DRST:  return word_t'(10);
            IX_MUX:   return word_t'(11);
            default:  return '1;
        endcase
    endfunction

    function automatic data_t reg_reset(input int unsigned ix);
        case (ix)
            IX_OSC:                     return OSC_RESET;
            IX_CPLL0, IX_DPLL0, IX_EPLL0: return PLL0_RESET;
            IX_CSEL:                    return CSEL_RESET;
            default:                    return '0;
        endcase
    endfunction

    function automatic data_t reg_force(input int unsigned ix);
        case (ix)
            IX_OSC:                     return OSC_FORCE;
            IX_CPLL0, IX_DPLL0, IX_EPLL0: return PLL0_FORCE;
            default:                    return '0;
        endcase
    endfunction

endpackage

// File: rtl/clkrst_decode.sv
module clkrst_decode
    import clkrst_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel,
    output logic                hit
);

    logic aligned;
    assign aligned = (addr[1:0] == 2'b00);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_match
        assign sel[i] = aligned && (addr[ADDR_W-1:2] == reg_word(i));
    end

    assign hit = |sel;

endmodule

// File: rtl/clkrst_regfile.sv
module clkrst_regfile
    import clkrst_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr,
    input  logic [NUM_REGS-1:0]            sel,
    input  data_t                          wdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0] q
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam data_t RST_VAL = reg_reset(i);
        localparam data_t FRC_VAL = reg_force(i);
        data_t val;

        always_ff @(posedge clk) begin
            if (rst) begin
                val <= RST_VAL;
            end else if (wr && sel[i]) begin
                val <= wdata | FRC_VAL;
            end
        end

        assign q[i] = val;
    end

endmodule

// File: rtl/clkrst_access.sv
module clkrst_access
    import clkrst_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            rd,
    input  logic                            wr,
    input  logic                            hit,
    input  logic [NUM_REGS-1:0]             sel,
    input  logic [NUM_REGS-1:0][DATA_W-1:0] q,
    output data_t                           rdata,
    output logic                            rvalid,
    output logic                            err
);

    acc_state_e state_q, state_d;
    data_t      rd_mux;
    data_t      rdata_q;

    // Read multiplexer: one-hot select, zero when nothing matches
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel[i]) begin
                rd_mux = rd_mux | q[i];
            end
        end
    end

    // Next-state logic
    always_comb begin
        if (rd) begin
            state_d = hit ? ACC_RDONE : ACC_RFAULT;
        end else if (wr) begin
            state_d = hit ? ACC_WDONE : ACC_WFAULT;
        end else begin
            state_d = ACC_IDLE;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Read data register (captured before any same-cycle write lands)
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd) begin
            rdata_q <= hit ? rd_mux : '0;
        end
    end

    // Outputs decoded from state
    always_comb begin
        rvalid = 1'b0;
        err    = 1'b0;
        unique case (state_q)
            ACC_IDLE:   ;
            ACC_RDONE:  rvalid = 1'b1;
            ACC_WDONE:  ;
            ACC_RFAULT: begin rvalid = 1'b1; err = 1'b1; end
            ACC_WFAULT: err = 1'b1;
            default:    ;
        endcase
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/clkrst_regs.sv
module clkrst_regs
    import clkrst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              bus_err,
    output logic [DATA_W-1:0] osc_cfg,
    output logic [DATA_W-1:0] core_pll_cfg0,
    output logic [DATA_W-1:0] ddr_pll_cfg0,
    output logic [DATA_W-1:0] ddr_pll_cfg1,
    output logic [DATA_W-1:0] eth_pll_cfg0,
    output logic [DATA_W-1:0] eth_pll_cfg1,
    output logic [DATA_W-1:0] core_clk_sel,
    output logic [DATA_W-1:0] dev_rst_mask,
    output logic [DATA_W-1:0] clk_mux_stat
);

    logic [NUM_REGS-1:0]             sel;
    logic                            hit;
    logic [NUM_REGS-1:0][DATA_W-1:0] q;

    clkrst_decode u_decode (
        .addr (bus_addr),
        .sel  (sel),
        .hit  (hit)
    );

    clkrst_regfile u_regfile (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .sel   (sel),
        .wdata (bus_wdata),
        .q     (q)
    );

    clkrst_access u_access (
        .clk    (clk),
        .rst    (rst),
        .rd     (bus_rd),
        .wr     (bus_wr),
        .hit    (hit),
        .sel    (sel),
        .q      (q),
        .rdata  (bus_rdata),
        .rvalid (bus_rvalid),
        .err    (bus_err)
    );

    assign osc_cfg       = q[IX_OSC];
    assign core_pll_cfg0 = q[IX_CPLL0];
    assign ddr_pll_cfg0  = q[IX_DPLL0];
    assign ddr_pll_cfg1  = q[IX_DPLL1];
    assign eth_pll_cfg0  = q[IX_EPLL0];
    assign eth_pll_cfg1  = q[IX_EPLL1];
    assign core_clk_sel  = q[IX_CSEL];
    assign dev_rst_mask  = q[IX_DRST];
    assign clk_mux_stat  = q[IX_MUX];

endmodule

// File: rtl/clkrst_regs_chk.sv
module clkrst_regs_chk (
    input logic        clk,
    input logic        rst,
    input logic [11:0] bus_addr,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        bus_rvalid,
    input logic        bus_err,
    input logic [31:0] osc_cfg,
    input logic [31:0] core_pll_cfg0,
    input logic [31:0] ddr_pll_cfg0,
    input logic [31:0] ddr_pll_cfg1,
    input logic [31:0] eth_pll_cfg0,
    input logic [31:0] eth_pll_cfg1,
    input logic [31:0] core_clk_sel,
    input logic [31:0] dev_rst_mask,
    input logic [31:0] clk_mux_stat
);

    p_reset_vals_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (osc_cfg == 32'hC000_0000) && (core_pll_cfg0 == 32'h8201_87C1)
                       && (core_clk_sel == 32'h1) && (dev_rst_mask == 32'h0));

    p_osc_write_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 12'h000) |=> osc_cfg == ($past(bus_wdata) | 32'h8000_0000));

    p_pll_forced_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 12'h00C) |=> ddr_pll_cfg0 == ($past(bus_wdata) | 32'h8200_0000));

    p_verbatim_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 12'h028) |=> dev_rst_mask == $past(bus_wdata));

    p_rvalid_after_rd_r5: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid);

    p_rvalid_only_rd_r5: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> !bus_rvalid);

    p_fault_read_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_rvalid && bus_err) |-> bus_rdata == 32'h0);

    p_fault_write_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_err && !bus_rvalid) |-> $stable(osc_cfg) && $stable(core_pll_cfg0)
            && $stable(ddr_pll_cfg0) && $stable(ddr_pll_cfg1) && $stable(eth_pll_cfg0)
            && $stable(eth_pll_cfg1) && $stable(core_clk_sel) && $stable(dev_rst_mask)
            && $stable(clk_mux_stat));

    p_err_needs_access_r8: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd || bus_wr) |=> !bus_err);

endmodule

bind clkrst_regs clkrst_regs_chk u_chk (.*);

// File: tb/clkrst_regs_bench.sv
module clkrst_regs_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid, bus_err;
    logic [31:0] osc_cfg, core_pll_cfg0, ddr_pll_cfg0, ddr_pll_cfg1;
    logic [31:0] eth_pll_cfg0, eth_pll_cfg1, core_clk_sel, dev_rst_mask, clk_mux_stat;

    always #2 clk = ~clk;

    clkrst_regs u_clkrst_regs (.*);

    int    n_vec  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    string tag    = "R1";

    // Behavioural model, indexed by word offset 0..15
    logic [31:0] mdl [16];
    logic [31:0] exp_rdata;
    bit          exp_rvalid, exp_err;
    int unsigned seed = 32'h1234_5678;

    function automatic bit is_mapped(input logic [11:0] a);
        int w;
        if (a[1:0] != 2'b00) return 1'b0;
        w = int'(a[11:2]);
        return (w == 0 || w == 1 || w == 3 || w == 4 || w == 7 ||
                w == 8 || w == 9 || w == 10 || w == 11);
    endfunction

    function automatic logic [31:0] force_bits(input int w);
        if (w == 0) return 32'h8000_0000;                       // R2
        if (w == 1 || w == 3 || w == 7) return 32'h8200_0000;   // R3
        return 32'h0;                                           // R4
    endfunction

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic compare_all();
        check(bus_rvalid == exp_rvalid, "rvalid", 32'(bus_rvalid), 32'(exp_rvalid));
        check(bus_err == exp_err, "err", 32'(bus_err), 32'(exp_err));
        check(bus_rdata == exp_rdata, "rdata", bus_rdata, exp_rdata);
        check(osc_cfg == mdl[0], "osc_cfg", osc_cfg, mdl[0]);
        check(core_pll_cfg0 == mdl[1], "core_pll_cfg0", core_pll_cfg0, mdl[1]);
        check(ddr_pll_cfg0 == mdl[3], "ddr_pll_cfg0", ddr_pll_cfg0, mdl[3]);
        check(ddr_pll_cfg1 == mdl[4], "ddr_pll_cfg1", ddr_pll_cfg1, mdl[4]);
        check(eth_pll_cfg0 == mdl[7], "eth_pll_cfg0", eth_pll_cfg0, mdl[7]);
        check(eth_pll_cfg1 == mdl[8], "eth_pll_cfg1", eth_pll_cfg1, mdl[8]);
        check(core_clk_sel == mdl[9], "core_clk_sel", core_clk_sel, mdl[9]);
        check(dev_rst_mask == mdl[10], "dev_rst_mask", dev_rst_mask, mdl[10]);
        check(clk_mux_stat == mdl[11], "clk_mux_stat", clk_mux_stat, mdl[11]);
    endtask

    // One bus cycle: compare the previous cycle's results, then drive and predict
    task automatic step(input bit rd, input bit wr, input logic [11:0] a,
                        input logic [31:0] d, input string t);
        bit ok;
        @(negedge clk);
        compare_all();
        tag       = t;
        bus_rd    = rd;
        bus_wr    = wr;
        bus_addr  = a;
        bus_wdata = d;
        ok = is_mapped(a);
        exp_rvalid = rd;
        exp_err    = (rd || wr) && !ok;
        if (rd) exp_rdata = ok ? mdl[int'(a[5:2])] : 32'h0;   // read before write (R9)
        if (wr && ok) mdl[int'(a[5:2])] = d | force_bits(int'(a[5:2]));
    endtask

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [11:0] map_offs [9];
        map_offs = '{12'h000, 12'h004, 12'h00C, 12'h010, 12'h01C,
                     12'h020, 12'h024, 12'h028, 12'h02C};
        // R1 reset values
        for (int i = 0; i < 16; i++) mdl[i] = 32'h0;
        mdl[0] = 32'hC000_0000;
        mdl[1] = 32'h8201_87C1;
        mdl[3] = 32'h8201_87C1;
        mdl[7] = 32'h8201_87C1;
        mdl[9] = 32'h0000_0001;
        exp_rdata = 32'h0; exp_rvalid = 1'b0; exp_err = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        tag = "R1";
        // R1 / R5: read every mapped register after reset
        foreach (map_offs[i]) step(1'b1, 1'b0, map_offs[i], 32'h0, "R1_R5");
        // R2: oscillator write with ready cleared by software
        step(1'b0, 1'b1, 12'h000, 32'h0000_0000, "R2");
        step(1'b1, 1'b0, 12'h000, 32'h0, "R2");
        step(1'b0, 1'b1, 12'h000, 32'h4000_1234, "R2");
        // R3: PLL config0 writes with lock and feedback cleared
        step(1'b0, 1'b1, 12'h004, 32'h0000_0000, "R3");
        step(1'b0, 1'b1, 12'h00C, 32'h7DFF_FFFF, "R3");
        step(1'b0, 1'b1, 12'h01C, 32'h0000_8042, "R3");
        step(1'b1, 1'b0, 12'h01C, 32'h0, "R3");
        // R4: verbatim registers, incl. config1 clock-enable bit 24
        step(1'b0, 1'b1, 12'h010, 32'h0100_0000, "R4");
        step(1'b0, 1'b1, 12'h020, 32'hFFFF_FFFF, "R4");
        step(1'b0, 1'b1, 12'h024, 32'h0000_0000, "R4");
        step(1'b0, 1'b1, 12'h028, 32'hA5A5_5A5A, "R4");
        step(1'b0, 1'b1, 12'h02C, 32'h0000_0003, "R4");
        step(1'b1, 1'b0, 12'h024, 32'h0, "R4");
        // R6 / R8: unmapped and misaligned reads
        step(1'b1, 1'b0, 12'h008, 32'h0, "R6_R8");
        step(1'b1, 1'b0, 12'h006, 32'h0, "R6_R8");
        step(1'b0, 1'b0, 12'h000, 32'h0, "R8");
        step(1'b1, 1'b0, 12'hFFC, 32'h0, "R6_R8");
        // R7 / R8: unmapped and misaligned writes
        step(1'b0, 1'b1, 12'h030, 32'hFFFF_FFFF, "R7_R8");
        step(1'b0, 1'b1, 12'h029, 32'h1111_1111, "R7_R8");
        step(1'b0, 1'b1, 12'h418, 32'h2222_2222, "R7_R8");
        // R9: simultaneous read and write on the same register
        step(1'b1, 1'b1, 12'h028, 32'h0F0F_0F0F, "R9");
        step(1'b1, 1'b1, 12'h004, 32'h0000_0005, "R9");
        step(1'b1, 1'b1, 12'h014, 32'hDEAD_BEEF, "R9");
        step(1'b1, 1'b0, 12'h028, 32'h0, "R9");
        // R10: pseudo-random mix of accesses
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            logic [11:0] a;
            r = rnd();
            a = {6'b0, r[5:0]};
            if (r[9:8] == 2'b11) a = r[31:20];
            step(r[6], r[7], a, rnd(), "R10");
        end
        step(1'b0, 1'b0, 12'h000, 32'h0, "R10");
        @(negedge clk);
        compare_all();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule